// File: doc/BRIEF.md
# Binary64 to Binary32 Narrowing Converter

This block takes an IEEE 754 double-precision operand and returns the nearest single-precision value under round-to-nearest-even. It also returns three exception flags: overflow, underflow and inexact. The block has one register stage. The operand presented before a rising clock edge appears converted, with its flags, right after that edge.

Normal inputs have their exponent moved from a bias of 1023 to a bias of 127. Their significand is cut from 53 to 24 bits, and the 29 dropped bits decide the rounding. Results too large for single precision become a signed infinity. Results below the smallest single normal are denormalised and then rounded, so they come out as single subnormals, as the smallest normal, or as a signed zero. NaNs, infinities, zeros and double subnormals each take a fixed path.

Top module: `dbl_to_sgl_cvt`

## Requirements
- R1: Input layout is sign at bit 63, exponent at 62:52 (bias 1023) and fraction at 51:0. Output layout is sign at bit 31, exponent at 30:23 (bias 127) and fraction at 22:0. A double that is exactly representable as a single normal converts with no flag set, e.g. 0x3FF0000000000000 -> 0x3F800000.
- R2: The 29 discarded fraction bits are rounded to nearest. An exact half rounds toward an even kept fraction, e.g. 0x3FF0000010000000 -> 0x3F800000 and 0x3FF0000030000000 -> 0x3F800002.
- R3: A rounding carry out of the 24-bit significand increments the output exponent and clears the fraction, e.g. 0x3FFFFFFFFFFFFFFF -> 0x40000000.
- R4: When the rounded exponent field would reach 255 or more, the output is infinity with the input sign (exponent 0xFF, fraction 0), and overflow and inexact are set.
- R5: A value below 2^-126 that is exact in single subnormal form comes out as that subnormal (exponent field 0) with no flag set, e.g. 0x36A0000000000000 -> 0x00000001.
- R6: Tiny values are rounded at the 2^-149 step. Exactly 2^-150 goes to signed zero, anything above it goes at least to 0x00000001, and anything below it goes to signed zero. A tiny value that rounds up to 2^-126 yields 0x00800000.
- R7: A double subnormal input (exponent 0, fraction nonzero) yields signed zero with inexact and underflow set.
- R8: A NaN input (exponent all ones, fraction nonzero) yields 0x7FC00000 with the input sign in bit 31, and no flag is set.
- R9: Infinity and zero inputs pass through as single infinity and zero with the same sign, and no flag is set.
- R10: Inexact is set exactly when any discarded bit is nonzero or an overflow occurs. Underflow is set when the unrounded value is below 2^-126 and the result is inexact.
- R11: The result and flags are registered with one cycle of latency. An active-low reset clears the result and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 64 | Binary64 operand |
| dout | output | 32 | Binary32 result, registered |
| ovf | output | 1 | Overflow flag, registered |
| unf | output | 1 | Underflow flag, registered |
| inx | output | 1 | Inexact flag, registered |

## Verification
The block holds no state beyond its output register, so any fault in the rounding, shift or classification logic shows on `dout` and the flags one cycle after the operand is applied. A shift amount that is off by one moves a subnormal result by a factor of two, or turns an exact half into a round-up. Such faults show up clearly at the subnormal boundaries and on tie inputs, where the exact result is known. A wrong overflow threshold shows up on the largest finite single and on its rounded-up neighbour.

// File: rtl/dbl_to_sgl_cvt.sv
module dbl_to_sgl_cvt #(
  parameter int XW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] din,
  output logic [31:0]   dout,
  output logic          ovf,
  output logic          unf,
  output logic          inx
);
  localparam int FW  = 52;
  localparam int EW  = 11;
  localparam int SHW = FW + 1 + 64;

  logic          s;
  logic [EW-1:0] e;
  logic [FW-1:0] f;
  assign s = din[XW-1];
  assign e = din[XW-2:FW];
  assign f = din[FW-1:0];

  logic e_max, e_zero, f_zero;
  assign e_max  = &e;
  assign e_zero = (e == '0);
  assign f_zero = (f == '0);

  logic signed [12:0] se;
  logic               tiny;
  assign se   = $signed({2'b00, e}) - 13'sd896;
  assign tiny = (se < 13'sd1);

  logic [5:0] sa;
  always_comb begin
    logic signed [12:0] t;
    t = 13'sd30 - se;
    if (!tiny)               sa = 6'd29;
    else if (se < -13'sd24)  sa = 6'd55;
    else                     sa = t[5:0];
  end

  logic [SHW-1:0] sh;
  logic [24:0]    q, r;
  logic           g, st, up;
  assign sh = {1'b1, f, 64'b0} >> sa;
  assign q  = sh[88:64];
  assign g  = sh[63];
  assign st = |sh[62:0];
  assign up = g & (st | q[0]);
  assign r  = q + {24'b0, up};

  logic signed [12:0] ef;
  logic               big;
  assign ef  = se + $signed({12'b0, r[24]});
  assign big = !tiny && (ef >= 13'sd255);

  logic [31:0] res;
  logic        o_n, u_n, x_n;
  always_comb begin
    o_n = 1'b0;
    u_n = 1'b0;
    x_n = 1'b0;
    if (e_max && !f_zero)       res = {s, 31'h7FC00000};
    else if (e_max)             res = {s, 31'h7F800000};
    else if (e_zero && f_zero)  res = {s, 31'h0};
    else if (e_zero) begin
      res = {s, 31'h0};
      u_n = 1'b1;
      x_n = 1'b1;
    end else if (big) begin
      res = {s, 31'h7F800000};
      o_n = 1'b1;
      x_n = 1'b1;
    end else if (tiny) begin
      res = {s, 7'b0, r[23], r[22:0]};
      x_n = g | st;
      u_n = g | st;
    end else begin
      res = {s, ef[7:0], r[22:0]};
      x_n = g | st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
      inx  <= 1'b0;
    end else begin
      dout <= res;
      ovf  <= o_n;
      unf  <= u_n;
      inx  <= x_n;
    end
  end

  // R4
  ovf_to_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (dout[30:0] == 31'h7F800000) && inx);

  // R10
  unf_needs_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> inx && (dout[30:24] == 7'b0) && !ovf);

  // R8
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(&din[62:52]) && $past(din[51:0] != '0))
      |-> dout == {$past(din[63]), 31'h7FC00000});

  // R9
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dout[31] == $past(din[63]));

  // R9
  inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(&din[62:52]) && $past(din[51:0] == '0))
      |-> (dout[30:0] == 31'h7F800000) && !ovf && !inx);
endmodule

// File: tb/dbl_to_sgl_cvt_test.sv
module dbl_to_sgl_cvt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] din = '0;
  logic [31:0] dout;
  logic        ovf, unf, inx;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbl_to_sgl_cvt uut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .dout(dout), .ovf(ovf), .unf(unf), .inx(inx)
  );

  task automatic check(input logic [63:0] x, input logic [31:0] ey,
                       input logic eo, input logic eu, input logic ex,
                       input string req);
    @(negedge clk);
    din = x;
    @(negedge clk);
    total++;
    if (dout !== ey || ovf !== eo || unf !== eu || inx !== ex) begin
      bad++;
      $display("FAIL %s in=%h got %h o%b u%b x%b expected %h o%b u%b x%b",
               req, x, dout, ovf, unf, inx, ey, eo, eu, ex);
    end
  endtask

  task automatic t_reset();
    total++;
    if (dout !== 32'h0 || ovf !== 1'b0 || unf !== 1'b0 || inx !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset got %h o%b u%b x%b expected 00000000 o0 u0 x0",
               dout, ovf, unf, inx);
    end
  endtask

  task automatic t_normal();
    check(64'h3FF0000000000000, 32'h3F800000, 0, 0, 0, "R1");
    check(64'hC004000000000000, 32'hC0200000, 0, 0, 0, "R1");
    check(64'h3810000000000000, 32'h00800000, 0, 0, 0, "R1");
    check(64'h400921FB54442D18, 32'h40490FDB, 0, 0, 1, "R10");
  endtask

  task automatic t_round();
    check(64'h3FF0000010000000, 32'h3F800000, 0, 0, 1, "R2");
    check(64'h3FF0000030000000, 32'h3F800002, 0, 0, 1, "R2");
    check(64'h3FF0000010000001, 32'h3F800001, 0, 0, 1, "R2");
    check(64'h3FF000000FFFFFFF, 32'h3F800000, 0, 0, 1, "R2");
  endtask

  task automatic t_carry();
    check(64'h3FFFFFFFFFFFFFFF, 32'h40000000, 0, 0, 1, "R3");
  endtask

  task automatic t_overflow();
    check(64'h47EFFFFFE0000000, 32'h7F7FFFFF, 0, 0, 0, "R4");
    check(64'h47EFFFFFF0000000, 32'h7F800000, 1, 0, 1, "R4");
    check(64'hFE37E43C8800759C, 32'hFF800000, 1, 0, 1, "R4");
  endtask

  task automatic t_subnormal();
    check(64'h36A0000000000000, 32'h00000001, 0, 0, 0, "R5");
    check(64'h3738000000000000, 32'h00000300, 0, 0, 0, "R5");
    check(64'h3690000000000000, 32'h00000000, 0, 1, 1, "R6");
    check(64'h3690000000000001, 32'h00000001, 0, 1, 1, "R6");
    check(64'h3680000000000000, 32'h00000000, 0, 1, 1, "R6");
    check(64'h8010000000000000, 32'h80000000, 0, 1, 1, "R6");
    check(64'h380FFFFFFFFFFFFF, 32'h00800000, 0, 1, 1, "R6");
  endtask

  task automatic t_dsub();
    check(64'h0000000000000001, 32'h00000000, 0, 1, 1, "R7");
    check(64'h800FFFFFFFFFFFFF, 32'h80000000, 0, 1, 1, "R7");
  endtask

  task automatic t_special();
    check(64'h7FF8000000000000, 32'h7FC00000, 0, 0, 0, "R8");
    check(64'hFFF0000000000001, 32'hFFC00000, 0, 0, 0, "R8");
    check(64'hFFF0000000000000, 32'hFF800000, 0, 0, 0, "R9");
    check(64'h7FF0000000000000, 32'h7F800000, 0, 0, 0, "R9");
    check(64'h8000000000000000, 32'h80000000, 0, 0, 0, "R9");
  endtask

  task automatic t_latency();
    @(negedge clk);
    din = 64'h3FF0000000000000;
    @(negedge clk);
    din = 64'h4000000000000000;
    total++;
    if (dout !== 32'h3F800000) begin
      bad++;
      $display("FAIL R11 latency got %h expected 3f800000", dout);
    end
    @(negedge clk);
    total++;
    if (dout !== 32'h40000000) begin
      bad++;
      $display("FAIL R11 latency got %h expected 40000000", dout);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_round();
    t_carry();
    t_overflow();
    t_subnormal();
    t_dsub();
    t_special();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule